// File: doc/BRIEF.md
# PLL Mode and Lock Status Register

This block holds the control and status logic that sits beside a clock synthesizer. Software programs the synthesizer through one of two control registers. The legacy register carries a predivider and a multiplier. The enhanced register carries configuration bits, an enhanced-mode enable, a predivider and a multiplier. The enhanced-mode bit decides which programming model governs the status bits. The block reports five status bits: bypass or normal mode, PLL select (PLL on), reference source, a live lock flag and a sticky lock flag. When a write alters a field that affects lock, the block emits a one-cycle pulse that asks the external lock detector to restart.

In the legacy model, mode and PLL select switch to normal on the first legacy write. The reference source stays at the value the reference pin had during reset. In the enhanced model, those three bits copy configuration bits 0, 1 and 2. The sticky lock flag sets when lock rises while a re-arm is pending. Reset and every lock-affecting change create a pending re-arm. The sticky flag clears on any loss of lock.

Top module: `pll_status_regs`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, mode, PLL select, live lock and sticky lock read 0. The reference-source bit equals the level of `ref_pin` during reset (1 = crystal, 0 = external clock).
- R2: While the enhanced-mode bit is 0, any write to address 0 (legacy control) sets mode and PLL select to 1 from the next cycle. This holds even if the write repeats the stored value. Both bits stay 1 afterwards.
- R3: The enhanced word at address 1 has the layout cfg[2:0] in bits 2..0, the enhanced-mode bit in bit 3, the predivider in bits 4 up, and the multiplier above it. While its enhanced-mode bit is 1, mode, PLL select and reference source equal cfg[0], cfg[1] and cfg[2].
- R4: While the enhanced-mode bit is 0, the reference-source bit does not change after reset, whatever `ref_pin` does.
- R5: With no lock-affecting change pending, live lock follows `lock_raw` one cycle later, in bypass as well as in normal mode.
- R6: A lock-affecting write forces live lock to 0 in the next cycle and pulses `relock_req` high for exactly that cycle. Live lock stays 0 until `lock_raw` has been seen low and then high again.
- R7: The first rise of live lock after reset sets the sticky flag, even while mode still shows bypass.
- R8: The sticky flag clears whenever live lock falls. It stays 0 through a later relock unless a re-arming event has occurred since the fall.
- R9: Two kinds of write are lock-affecting and re-arm the sticky flag. The first is a legacy write, made while the enhanced-mode bit is 0, that changes the predivider (bits 0 up) or the multiplier (above it). The second is an enhanced write, made while the old or new enhanced-mode bit is 1, that changes the enhanced-mode bit, cfg[2:1], the predivider or the multiplier.
- R10: Some writes are not lock-affecting and leave both lock flags and `relock_req` unchanged. These are a write that repeats the stored fields, an enhanced write that changes only cfg[0] (including normal to bypass), and a legacy write while the enhanced-mode bit is 1.
- R11: Reading address 2 returns the status word: bit 0 live lock, bit 1 sticky, bit 2 reference source, bit 3 PLL select, bit 4 mode, higher bits 0. Writes to address 2 or 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pin | input | 1 | Reference-select level, sampled while in reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 legacy, 1 enhanced, 2 status |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| lock_raw | input | 1 | Raw lock indication from the lock detector |
| mode_o | output | 1 | 1 = normal, 0 = bypass |
| pll_sel_o | output | 1 | PLL select / PLL on |
| ref_src_o | output | 1 | 1 = crystal, 0 = external clock |
| lock_o | output | 1 | Live lock flag |
| lock_sticky_o | output | 1 | Sticky lock flag |
| relock_req | output | 1 | One-cycle request to restart lock detection |

## Verification
The bench builds the block with narrow fields: a 2-bit legacy predivider, a 3-bit legacy multiplier, a 3-bit enhanced predivider and a 4-bit enhanced multiplier, on a 16-bit data bus. The bench derives every field position from these values on its own. Narrow fields make it quick to form a write that changes exactly one field and a write that repeats the stored value exactly. Those two kinds of write are the cases that separate the re-arm rules from the no-change rules.

// File: rtl/pll_stat_pkg.sv
// Package: shared addresses and the packed status layout of the PLL status block.
// Assumes a two-bit register address space.
package pll_stat_pkg;

    localparam logic [1:0] ADDR_LEG  = 2'd0;
    localparam logic [1:0] ADDR_ENH  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // Bit order of this struct is the read-back order of the status word.
    typedef struct packed {
        logic mode;
        logic pll_sel;
        logic ref_src;
        logic locks;
        logic lock;
    } stat_word_t;

    localparam int STAT_W = $bits(stat_word_t);

endpackage

// File: rtl/pll_ctrl_regs.sv
// Module: pll_ctrl_regs
// Holds the legacy and enhanced control words, remembers the first legacy
// write, and flags writes that change lock-affecting fields.
// Assumes wr_* are synchronous to clk and DATA_W covers both words.
module pll_ctrl_regs
    import pll_stat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LPRE_W = 3,
    parameter int LMFD_W = 3,
    parameter int EPRE_W = 4,
    parameter int EMFD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LPRE_W+LMFD_W-1:0]    leg_word,
    output logic [4+EPRE_W+EMFD_W-1:0]  enh_word,
    output logic              leg_seen,
    output logic              change_evt
);
    localparam int LEG_W = LPRE_W + LMFD_W;
    localparam int ENH_W = 4 + EPRE_W + EMFD_W;
    localparam int EMODE_BIT = 3;

    logic [LEG_W-1:0] leg_q;
    logic [ENH_W-1:0] enh_q;
    logic             seen_q;
    logic             wr_leg, wr_enh;
    logic             leg_evt, enh_evt;
    logic [LEG_W-1:0] leg_new;
    logic [ENH_W-1:0] enh_new;
    logic             unused_wr;

    assign unused_wr = ^wr_data;
    assign leg_new   = wr_data[LEG_W-1:0];
    assign enh_new   = wr_data[ENH_W-1:0];
    assign wr_leg    = wr_en && (wr_addr == ADDR_LEG);
    assign wr_enh    = wr_en && (wr_addr == ADDR_ENH);

    // Decide whether this cycle's write changes a lock-affecting field.
    always_comb begin
        leg_evt = wr_leg && !enh_q[EMODE_BIT] && (leg_new != leg_q);
        enh_evt = wr_enh && (enh_new[EMODE_BIT] || enh_q[EMODE_BIT])
                  && (enh_new[ENH_W-1:1] != enh_q[ENH_W-1:1]);
    end

    assign change_evt = leg_evt || enh_evt;

    // Store control words and the first-legacy-write flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg_q  <= '0;
            enh_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (wr_leg) begin
                leg_q <= leg_new;
                if (!enh_q[EMODE_BIT]) seen_q <= 1'b1;
            end
            if (wr_enh) enh_q <= enh_new;
        end
    end

    assign leg_word = leg_q;
    assign enh_word = enh_q;
    assign leg_seen = seen_q;

    AST_LEG_SEEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seen_q) && $past(rst_n) |-> seen_q); // R2
    AST_REPEAT_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_leg && leg_new == leg_q && !wr_enh) |-> !change_evt); // R10

endmodule

// File: rtl/pll_lock_track.sv
// Module: pll_lock_track
// Produces the live and sticky lock flags from the raw detector output and
// the change events; issues the restart request.
// Assumes lock_raw is already synchronous to clk.
module pll_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_raw,
    input  logic change_evt,
    output logic lock_o,
    output logic locks_o,
    output logic relock_req_o
);
    logic lock_q, lock_d;
    logic locks_q, locks_d;
    logic arm_q, arm_d;
    logic blank_q;
    logic req_q;

    // Next live lock: forced low on a change, masked until raw lock restarts.
    always_comb lock_d = !change_evt && lock_raw && !blank_q;

    // Next sticky flag and re-arm state from the live lock edges.
    always_comb begin
        locks_d = locks_q;
        arm_d   = arm_q || change_evt;
        if (lock_q && !lock_d) begin
            locks_d = 1'b0;
        end else if (!lock_q && lock_d && arm_q) begin
            locks_d = 1'b1;
            arm_d   = 1'b0;
        end
    end

    // Register lock flags, the blanking window and the restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            locks_q <= 1'b0;
            arm_q   <= 1'b1;
            blank_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            lock_q  <= lock_d;
            locks_q <= locks_d;
            arm_q   <= arm_d;
            req_q   <= change_evt;
            if (change_evt)     blank_q <= 1'b1;
            else if (!lock_raw) blank_q <= 1'b0;
        end
    end

    assign lock_o       = lock_q;
    assign locks_o      = locks_q;
    assign relock_req_o = req_q;

    AST_DROP_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        change_evt |=> !lock_q); // R6
    AST_REQ_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        change_evt |=> req_q); // R6
    AST_STICKY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        locks_q |-> lock_q); // R8
    AST_STICKY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locks_q) && $past(rst_n) |-> $past(arm_q)); // R9

endmodule

// File: rtl/pll_status_view.sv
// Module: pll_status_view
// Captures the reference pin during reset, selects the status bits for the
// active programming model, and drives the read mux.
// Assumes ref_pin is stable for the reset cycles.
module pll_status_view
    import pll_stat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEG_W  = 6,
    parameter int ENH_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pin,
    input  logic [LEG_W-1:0]  leg_word,
    input  logic [ENH_W-1:0]  enh_word,
    input  logic              leg_seen,
    input  logic              lock,
    input  logic              locks,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output stat_word_t        stat
);
    logic ref_q;
    logic emode;

    assign emode = enh_word[3];

    // Sample the reference-select pin while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= ref_pin;
    end

    // Pick status bits according to the programming model.
    always_comb begin
        stat.lock  = lock;
        stat.locks = locks;
        if (emode) begin
            stat.mode    = enh_word[0];
            stat.pll_sel = enh_word[1];
            stat.ref_src = enh_word[2];
        end else begin
            stat.mode    = leg_seen;
            stat.pll_sel = leg_seen;
            stat.ref_src = ref_q;
        end
    end

    // Read mux over the register map.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_LEG:  rd_data[LEG_W-1:0]  = leg_word;
            ADDR_ENH:  rd_data[ENH_W-1:0]  = enh_word;
            ADDR_STAT: rd_data[STAT_W-1:0] = stat;
            default:   rd_data = '0;
        endcase
    end

    AST_LEGACY_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!emode && $past(!emode) && $past(rst_n)) |-> $stable(stat.ref_src)); // R4

endmodule

// File: rtl/pll_status_regs.sv
// Module: pll_status_regs (top)
// Status and control register block for a clock synthesizer with legacy
// and enhanced programming models. Assumes a single clock domain.
module pll_status_regs
    import pll_stat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LPRE_W = 3,
    parameter int LMFD_W = 3,
    parameter int EPRE_W = 4,
    parameter int EMFD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pin,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              lock_raw,
    output logic              mode_o,
    output logic              pll_sel_o,
    output logic              ref_src_o,
    output logic              lock_o,
    output logic              lock_sticky_o,
    output logic              relock_req
);
    localparam int LEG_W = LPRE_W + LMFD_W;
    localparam int ENH_W = 4 + EPRE_W + EMFD_W;

    logic [LEG_W-1:0] leg_word;
    logic [ENH_W-1:0] enh_word;
    logic             leg_seen, change_evt;
    logic             lock_w, locks_w;
    stat_word_t       stat;

    pll_ctrl_regs #(
        .DATA_W(DATA_W), .LPRE_W(LPRE_W), .LMFD_W(LMFD_W),
        .EPRE_W(EPRE_W), .EMFD_W(EMFD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .leg_word(leg_word), .enh_word(enh_word),
        .leg_seen(leg_seen), .change_evt(change_evt)
    );

    pll_lock_track u_lock (
        .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .change_evt(change_evt),
        .lock_o(lock_w), .locks_o(locks_w), .relock_req_o(relock_req)
    );

    pll_status_view #(
        .DATA_W(DATA_W), .LEG_W(LEG_W), .ENH_W(ENH_W)
    ) u_view (
        .clk(clk), .rst_n(rst_n), .ref_pin(ref_pin), .leg_word(leg_word),
        .enh_word(enh_word), .leg_seen(leg_seen), .lock(lock_w),
        .locks(locks_w), .rd_addr(rd_addr), .rd_data(rd_data), .stat(stat)
    );

    assign mode_o        = stat.mode;
    assign pll_sel_o     = stat.pll_sel;
    assign ref_src_o     = stat.ref_src;
    assign lock_o        = lock_w;
    assign lock_sticky_o = locks_w;

endmodule

// File: tb/sim_pll_status_regs.sv
module sim_pll_status_regs;
    localparam int DW = 16, LP = 2, LM = 3, EP = 3, EM = 4;

    logic clk = 1'b0, rst_n = 1'b0, ref_pin = 1'b1, wr_en = 1'b0, lock_raw = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic mode_o, pll_sel_o, ref_src_o, lock_o, lock_sticky_o, relock_req;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pll_status_regs #(.DATA_W(DW), .LPRE_W(LP), .LMFD_W(LM), .EPRE_W(EP), .EMFD_W(EM)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_pin(ref_pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .lock_raw(lock_raw),
        .mode_o(mode_o), .pll_sel_o(pll_sel_o), .ref_src_o(ref_src_o), .lock_o(lock_o),
        .lock_sticky_o(lock_sticky_o), .relock_req(relock_req));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [DW-1:0] leg(input int pre, input int mfd);
        return DW'((mfd << LP) | pre);
    endfunction

    function automatic logic [DW-1:0] enh(input int cfg, input int em, input int pre, input int mfd);
        return DW'((mfd << (4 + EP)) | (pre << 4) | (em << 3) | cfg);
    endfunction

    task automatic relock();
        lock_raw = 1'b0; tick();
        lock_raw = 1'b1; tick();
    endtask

    task automatic flags(input string req, input int lk, input int lks);
        chk({req, " lock"}, lock_o, lk);
        chk({req, " sticky"}, lock_sticky_o, lks);
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_o, 0); chk("R1 pllsel", pll_sel_o, 0);
        chk("R1 ref", ref_src_o, 1); flags("R1", 0, 0);
        ref_pin = 1'b0; tick(); tick();
        chk("R4 ref held", ref_src_o, 1);
    endtask

    task automatic t_bypass_lock();
        lock_raw = 1'b1; tick();
        flags("R7 R5 bypass", 1, 1); chk("R7 still bypass", mode_o, 0);
        lock_raw = 1'b0; tick(); flags("R8 loss", 0, 0);
        lock_raw = 1'b1; tick(); flags("R8 no rearm", 1, 0);
    endtask

    task automatic t_legacy();
        wr(2'd0, leg(1, 2));
        chk("R2 mode", mode_o, 1); chk("R2 pllsel", pll_sel_o, 1);
        chk("R6 req", relock_req, 1); chk("R6 drop", lock_o, 0);
        tick(); chk("R6 req one cycle", relock_req, 0); chk("R6 blanked", lock_o, 0);
        relock(); flags("R9 legacy rearm", 1, 1);
        wr(2'd0, leg(1, 2));
        flags("R10 same write", 1, 1); chk("R10 no req", relock_req, 0);
    endtask

    task automatic t_enhanced();
        wr(2'd1, enh(3, 1, 0, 0));
        chk("R3 mode", mode_o, 1); chk("R3 pllsel", pll_sel_o, 1); chk("R3 ref", ref_src_o, 0);
        flags("R9 emode change", 0, 0);
        relock(); flags("R9 enh rearm", 1, 1);
        wr(2'd1, enh(2, 1, 0, 0));
        chk("R3 bypass", mode_o, 0); flags("R10 cfg0 only", 1, 1);
        wr(2'd0, leg(3, 2));
        flags("R10 legacy in enh", 1, 1); chk("R10 no req", relock_req, 0);
        wr(2'd1, enh(6, 1, 0, 0));
        chk("R3 ref mirror", ref_src_o, 1); flags("R9 cfg2 change", 0, 0);
        relock(); flags("R9 cfg2 rearm", 1, 1);
        wr(2'd1, enh(6, 1, 5, 0));
        flags("R9 epre change", 0, 0); relock();
    endtask

    task automatic t_readback();
        rd_addr = 2'd2; #1;
        chk("R11 status", rd_data, 16'h000F);
        wr(2'd2, '1); wr(2'd3, '1);
        rd_addr = 2'd2; #1;
        chk("R11 write ignored", rd_data, 16'h000F);
        rd_addr = 2'd1; #1;
        chk("R11 enh readback", rd_data, enh(6, 1, 5, 0));
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; tick();
        t_reset();
        t_bypass_lock();
        t_legacy();
        t_enhanced();
        t_readback();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end
endmodule